// File: doc/BRIEF.md
# System Clock Resuscitation Monitor

This block watches a monitored system clock from the domain of a reference clock that always runs. The monitored clock's level passes through a two-stage synchronizer. A rising edge of the synchronized level restarts a counter that runs on the reference clock. If the counter reaches a programmable timeout before the next edge arrives, the block sets a sticky fault flag. While the flag is set, the block drives a mux-override output that tells the surrounding glitchless mux to run the system from the reference clock.

Software configures the block through a simple write port. A test-force action raises the fault at once, so the recovery path can be tried without stopping a clock. The flag stays set until software, after repairing the clock, writes the clear action. An interrupt output combines the fault with an interrupt enable and adds a separate force term. The block contains no data stream, so every pin is a plain control or status signal.

Top module: `sysclk_resus_mon`

## Requirements
- R1: After reset, `use_ref_clk` and `irq` are 0, monitoring is disabled, interrupt enable and interrupt force are 0, and the timeout (address 0) is 255.
- R2: While the enable bit (address 1, bit 0) is 0, a stopped monitored clock never sets the fault.
- R3: With monitoring enabled and the monitored clock rising every 4 reference cycles, a timeout of 4 never sets the fault.
- R4: With monitoring enabled and the monitored clock stopped after a rising edge, `use_ref_clk` rises on exactly the (T+4)-th reference rising edge after that monitored edge, where T is the timeout. This count is 2 synchronizer stages, 1 edge stage, T counts and 1 flag stage. With the same 4-cycle monitored clock, a timeout of 3 sets the fault.
- R5: Writing 1 to the force bit (address 1, bit 1) sets the fault at the next reference edge, with or without monitoring enabled.
- R6: Once set, the fault stays set while the monitored clock runs again, until a clear is written.
- R7: Writing 1 to the clear bit (address 1, bit 2) drops the fault at the next reference edge when no timeout is pending.
- R8: A write that sets force and clear together leaves the fault set.
- R9: `irq` equals (fault AND interrupt enable at address 2, bit 0) OR interrupt force at address 3, bit 0. The force term raises `irq` with no fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Always-running reference clock |
| ref_rst_n | input | 1 | Active-low reset, synchronous to ref_clk |
| mon_clk | input | 1 | Monitored system clock, sampled as data |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register address: 0 timeout, 1 control, 2 interrupt enable, 3 interrupt force |
| cfg_wdata | input | 8 | Write data |
| use_ref_clk | output | 1 | Mux override: 1 selects the reference clock |
| irq | output | 1 | Masked and forced fault interrupt |

## Verification
The hardest situation to reach from the ports is the exact timeout instant. The bench must know when the last monitored edge occurred relative to the reference edges. To get there, the bench gates its generated monitored clock right after a rising edge, on a half-cycle offset from the reference clock. It then counts reference edges until the override rises, both with the reset timeout of 255 and at the 3-versus-4 boundary against a 4-cycle monitored clock.

// File: rtl/resus_pkg.sv
package resus_pkg;
  localparam int ADDR_W = 2;

  localparam logic [ADDR_W-1:0] ADDR_TIMEOUT = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_CTRL    = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_INT_EN  = 2'd2;
  localparam logic [ADDR_W-1:0] ADDR_INT_FRC = 2'd3;

  // control register bit positions
  localparam int CTRL_EN    = 0;
  localparam int CTRL_FORCE = 1;
  localparam int CTRL_CLEAR = 2;
  localparam int CTRL_USED  = 3;

  typedef struct packed {
    logic mon_en;
    logic int_en;
    logic int_frc;
  } resus_cfg_t;
endpackage

// File: rtl/resus_sync.sv
module resus_sync #(
  parameter int STAGES = 2
) (
  input  logic ref_clk,
  input  logic ref_rst_n,
  input  logic async_in,
  output logic rise_o
);
  localparam int TOTAL = STAGES + 1;

  logic [TOTAL-1:0] chain_q;

  always_ff @(posedge ref_clk) begin
    if (!ref_rst_n) chain_q[0] <= 1'b0;
    else            chain_q[0] <= async_in;
  end

  for (genvar s = 1; s < TOTAL; s++) begin : g_stage
    always_ff @(posedge ref_clk) begin
      if (!ref_rst_n) chain_q[s] <= 1'b0;
      else            chain_q[s] <= chain_q[s-1];
    end
  end

  // chain_q[STAGES-1] is the synchronized level, chain_q[STAGES] its delay
  assign rise_o = chain_q[STAGES-1] & ~chain_q[STAGES];
endmodule

// File: rtl/resus_cfg.sv
module resus_cfg
  import resus_pkg::*;
#(
  parameter int TO_W = 8
) (
  input  logic              ref_clk,
  input  logic              ref_rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [TO_W-1:0]   wdata,
  output logic [TO_W-1:0]   timeout_o,
  output resus_cfg_t        cfg_o,
  output logic              force_p_o,
  output logic              clear_p_o
);
  logic ctrl_wr;
  assign ctrl_wr = we && (addr == ADDR_CTRL);

  always_ff @(posedge ref_clk) begin
    if (!ref_rst_n) begin
      timeout_o <= '1;
      cfg_o     <= '0;
    end else if (we) begin
      case (addr)
        ADDR_TIMEOUT: timeout_o     <= wdata;
        ADDR_CTRL:    cfg_o.mon_en  <= wdata[CTRL_EN];
        ADDR_INT_EN:  cfg_o.int_en  <= wdata[0];
        default:      cfg_o.int_frc <= wdata[0];
      endcase
    end
  end

  // force and clear are write-one actions, not stored
  assign force_p_o = ctrl_wr && wdata[CTRL_FORCE];
  assign clear_p_o = ctrl_wr && wdata[CTRL_CLEAR];

  logic unused_wdata_hi;
  assign unused_wdata_hi = ^wdata[TO_W-1:CTRL_USED];
endmodule

// File: rtl/resus_timer.sv
module resus_timer #(
  parameter int TO_W = 8
) (
  input  logic            ref_clk,
  input  logic            ref_rst_n,
  input  logic            en,
  input  logic            restart,
  input  logic [TO_W-1:0] timeout,
  output logic            fire_o
);
  logic [TO_W-1:0] cnt_q;

  always_ff @(posedge ref_clk) begin
    if (!ref_rst_n)           cnt_q <= '0;
    else if (!en || restart)  cnt_q <= '0;
    else if (cnt_q != '1)     cnt_q <= cnt_q + 1'b1;
  end

  assign fire_o = en && (cnt_q >= timeout);
endmodule

// File: rtl/sysclk_resus_mon.sv
module sysclk_resus_mon
  import resus_pkg::*;
#(
  parameter int TO_W        = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              ref_clk,
  input  logic              ref_rst_n,
  input  logic              mon_clk,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [TO_W-1:0]   cfg_wdata,
  output logic              use_ref_clk,
  output logic              irq
);
  logic [TO_W-1:0] timeout;
  resus_cfg_t      cfg;
  logic            force_p, clear_p, mon_rise, fire, flag_q;

  resus_cfg #(.TO_W(TO_W)) u_cfg (
    .ref_clk   (ref_clk),
    .ref_rst_n (ref_rst_n),
    .we        (cfg_we),
    .addr      (cfg_addr),
    .wdata     (cfg_wdata),
    .timeout_o (timeout),
    .cfg_o     (cfg),
    .force_p_o (force_p),
    .clear_p_o (clear_p)
  );

  resus_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .ref_clk   (ref_clk),
    .ref_rst_n (ref_rst_n),
    .async_in  (mon_clk),
    .rise_o    (mon_rise)
  );

  resus_timer #(.TO_W(TO_W)) u_timer (
    .ref_clk   (ref_clk),
    .ref_rst_n (ref_rst_n),
    .en        (cfg.mon_en),
    .restart   (mon_rise | clear_p),
    .timeout   (timeout),
    .fire_o    (fire)
  );

  // set causes take priority over clear
  always_ff @(posedge ref_clk) begin
    if (!ref_rst_n)           flag_q <= 1'b0;
    else if (force_p || fire) flag_q <= 1'b1;
    else if (clear_p)         flag_q <= 1'b0;
  end

  assign use_ref_clk = flag_q;
  assign irq         = (flag_q & cfg.int_en) | cfg.int_frc;
endmodule

// File: rtl/resus_mon_chk.sv
module resus_mon_chk (
  input logic ref_clk,
  input logic ref_rst_n,
  input logic flag,
  input logic fire,
  input logic force_p,
  input logic clear_p,
  input logic mon_en,
  input logic int_frc,
  input logic irq
);
  AST_FORCE_SETS_FLAG: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
    force_p |=> flag); // R5
  AST_FLAG_STICKY: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
    flag && !clear_p |=> flag); // R6
  AST_CLEAR_DROPS: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
    clear_p && !force_p && !fire |=> !flag); // R7
  AST_NO_CAUSELESS_SET: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
    !flag && !force_p && !fire |=> !flag); // R4
  AST_IDLE_WHEN_OFF: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
    !mon_en |-> !fire); // R2
  AST_FORCE_IRQ: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
    int_frc |-> irq); // R9
endmodule

bind sysclk_resus_mon resus_mon_chk u_chk (
  .ref_clk   (ref_clk),
  .ref_rst_n (ref_rst_n),
  .flag      (flag_q),
  .fire      (fire),
  .force_p   (force_p),
  .clear_p   (clear_p),
  .mon_en    (cfg.mon_en),
  .int_frc   (cfg.int_frc),
  .irq       (irq)
);

// File: tb/test_sysclk_resus_mon.sv
module test_sysclk_resus_mon;
  logic       ref_clk = 1'b0;
  logic       ref_rst_n = 1'b0;
  logic       mon_clk = 1'b0;
  logic       mon_run = 1'b1;
  logic       cfg_we = 1'b0;
  logic [1:0] cfg_addr = '0;
  logic [7:0] cfg_wdata = '0;
  logic       use_ref_clk, irq;
  int total = 0;
  int bad = 0;

  sysclk_resus_mon i_sysclk_resus_mon (
    .ref_clk, .ref_rst_n, .mon_clk, .cfg_we, .cfg_addr, .cfg_wdata,
    .use_ref_clk, .irq
  );

  always #5 ref_clk = ~ref_clk;            // 100 MHz
  always #20 mon_clk = mon_run ? ~mon_clk : 1'b0;  // rises every 4 ref cycles

  // {addr, data, expected use_ref_clk, expected irq}
  localparam int NV = 10;
  localparam logic [11:0] VEC [NV] = '{
    {2'd0, 8'd20,  1'b0, 1'b0},  // timeout 20
    {2'd1, 8'h01,  1'b0, 1'b0},  // enable, R3
    {2'd3, 8'h01,  1'b0, 1'b1},  // R9 force term alone
    {2'd3, 8'h00,  1'b0, 1'b0},  // R9
    {2'd1, 8'h03,  1'b1, 1'b0},  // R5 force, irq masked
    {2'd2, 8'h01,  1'b1, 1'b1},  // R9 enable unmasks
    {2'd1, 8'h05,  1'b0, 1'b0},  // R7 clear
    {2'd1, 8'h07,  1'b1, 1'b1},  // R8 force beats clear
    {2'd1, 8'h05,  1'b0, 1'b0},  // R7
    {2'd2, 8'h00,  1'b0, 1'b0}   // R9
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge ref_clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge ref_clk);
    cfg_we = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge ref_clk);
  endtask

  // count ref edges from a monitored rising edge until the override rises
  task automatic stop_and_time(output int n);
    @(posedge mon_clk);
    mon_run = 1'b0;
    n = 0;
    while (!use_ref_clk && n < 1000) begin
      @(posedge ref_clk);
      #1;
      n++;
    end
  endtask

  initial begin
    repeat (150000) @(posedge ref_clk);
    bad++; total++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n;
    idle(4);
    ref_rst_n = 1'b1;
    idle(2);
    check("R1 override", use_ref_clk, 0);
    check("R1 irq", irq, 0);
    // R1/R4: reset timeout 255 -> override on edge 259
    wr(2'd1, 8'h01);
    idle(8);
    stop_and_time(n);
    check("R1 R4 default timeout edges", n, 259);
    mon_run = 1'b1;
    idle(50);
    check("R6 sticky with clock back", use_ref_clk, 1);
    wr(2'd1, 8'h05);
    check("R7 clear", use_ref_clk, 0);

    for (int i = 0; i < NV; i++) begin
      @(negedge ref_clk);
      cfg_we = 1'b1; cfg_addr = VEC[i][11:10]; cfg_wdata = VEC[i][9:2];
      @(negedge ref_clk);
      cfg_we = 1'b0;
      check($sformatf("vec%0d R5 R7 R8 override", i), use_ref_clk, VEC[i][1]);
      check($sformatf("vec%0d R9 irq", i), irq, VEC[i][0]);
    end

    // R2: disabled, stopped clock, no fault
    wr(2'd1, 8'h00);
    wr(2'd0, 8'd3);
    mon_run = 1'b0;
    idle(300);
    check("R2 disabled no fault", use_ref_clk, 0);
    // R5 with monitoring off
    wr(2'd1, 8'h02);
    check("R5 force while disabled", use_ref_clk, 1);
    mon_run = 1'b1;
    idle(10);
    wr(2'd1, 8'h04);
    check("R7 clear while disabled", use_ref_clk, 0);

    // R3: timeout 4 vs 4-cycle monitored clock
    wr(2'd0, 8'd4);
    wr(2'd1, 8'h01);
    idle(200);
    check("R3 timeout 4 no fault", use_ref_clk, 0);
    // R4 boundary: timeout 3 fires
    wr(2'd0, 8'd3);
    idle(20);
    check("R4 timeout 3 fires", use_ref_clk, 1);
    wr(2'd0, 8'd10);
    wr(2'd1, 8'h05);
    check("R7 clear after boundary", use_ref_clk, 0);
    // R4 exact timing with short timeout
    idle(8);
    stop_and_time(n);
    check("R4 timeout 10 edges", n, 14);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule